// File: doc/BRIEF.md
# Function-Unit to Register Dependency Matrix

This block holds, for every function unit in an out-of-order core, the register numbers of the instruction that unit is working on. The function units themselves carry operand values only and never see register numbers. When an instruction is issued to a unit, that unit's row in the matrix records the destination, first-source and second-source register numbers. Each number is kept as a one-hot field with one bit per architectural register. From then on the row alone turns the unit's operand requests into register-file enable lines.

The issue interface is valid/ready. An issue is taken only on a cycle where `issue_valid` and `issue_ready` are both high. `issue_ready` is low when the addressed row is still occupied, or is being released in that cycle. An issue offered while ready is low is dropped and is not held. The caller must keep the instruction and offer it again. Operand requests, completion pulses and all outputs are plain level signals.

Per-register OR reductions across all rows report which registers still have a pending read and which have a pending write, for use by hazard detection. Enable lines from different rows are OR-ed onto each register line. Port arbitration upstream keeps at most one requesting row per port.

Top module: `fu_reg_matrix`

## Requirements
- R1: After reset, `fu_busy`, `rd_pend`, `wr_pend` and all three enable vectors are zero, and `issue_ready` is high for every in-range unit.
- R2: An issue is accepted on a clock edge where `issue_valid` and `issue_ready` are both high. From the next cycle, `fu_busy` bit `issue_fu` is 1.
- R3: Each operand slot of a row latches a one-hot field, with bit k set for register k, only when its enable flag (`issue_dst_en`, `issue_src1_en`, `issue_src2_en`) is high. A disabled slot latches all zeros and never produces an enable.
- R4: With `rd_req` bit 2·f high, `rd_en_a` carries the first-source field of row f. With `rd_req` bit 2·f+1 high, `rd_en_b` carries the second-source field of row f. Both are combinational in the same cycle.
- R5: With `wr_req` bit f high, `wr_en` carries the destination field of row f in the same cycle.
- R6: A request from a row that is not busy drives no enable line.
- R7: Bit k of `rd_pend` is the OR over all rows of their source fields' bit k. Bit k of `wr_pend` is the OR of their destination fields' bit k.
- R8: A pulse on `done` bit f clears row f, meaning its busy flag and all three fields, at the next edge. A busy row without `done` keeps its contents.
- R9: While row `issue_fu` is busy, or its `done` bit is high, `issue_ready` is low, and an offered issue leaves every row unchanged.
- R10: Requests from several rows on the same port OR their fields onto that port's enable vector.
- R11: A row's fields take effect the cycle after issue. A request in the issue cycle itself yields no enable from that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue offered |
| issue_ready | output | 1 | Target row free to accept the issue |
| issue_fu | input | FUW | Target function unit (row) |
| issue_dst | input | REGW | Destination register number |
| issue_src1 | input | REGW | First source register number |
| issue_src2 | input | REGW | Second source register number |
| issue_dst_en | input | 1 | Destination slot used |
| issue_src1_en | input | 1 | First source slot used |
| issue_src2_en | input | 1 | Second source slot used |
| rd_req | input | 2·NUM_FU | Operand read requests, bit 2f for source 1 and bit 2f+1 for source 2 of unit f |
| wr_req | input | NUM_FU | Result write request per unit |
| done | input | NUM_FU | Completion or cancel pulse per unit, which clears the row |
| rd_en_a | output | NUM_REG | Register-file read enables, first-source port |
| rd_en_b | output | NUM_REG | Register-file read enables, second-source port |
| wr_en | output | NUM_REG | Register-file write enables |
| rd_pend | output | NUM_REG | Register has a pending read in some row |
| wr_pend | output | NUM_REG | Register has a pending write in some row |
| fu_busy | output | NUM_FU | Row occupied |

## Verification
Two pairs of events can meet in one cycle. A completion pulse can arrive on the same edge as a new issue aimed at that row. An operand request can arrive in the very cycle its row is being written. The bench provokes the first by driving `done` and a valid issue to the same unit together. It judges the result from `issue_ready` being low in that cycle, and from busy and pending vectors that are all zero afterwards. For the second, it holds a request across the issue edge and expects a zero enable before the edge and the latched field after it.

// File: rtl/fureg_pkg.sv
package fureg_pkg;
  localparam int NSLOT = 3;
  typedef enum int {
    SLOT_DST  = 0,
    SLOT_SRC1 = 1,
    SLOT_SRC2 = 2
  } slot_e;
endpackage

// File: rtl/fureg_onehot.sv
module fureg_onehot #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [W-1:0] idx,
  input  logic         en,
  output logic [N-1:0] vec
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign vec[i] = en && (idx == W'(i));
  end
endmodule

// File: rtl/fureg_colreduce.sv
module fureg_colreduce #(
  parameter int ROWS = 4,
  parameter int COLS = 8
) (
  input  logic [ROWS-1:0][COLS-1:0] rows_in,
  output logic [COLS-1:0]           col_or
);
  always_comb begin
    col_or = '0;
    for (int r = 0; r < ROWS; r++) col_or = col_or | rows_in[r];
  end
endmodule

// File: rtl/fureg_row.sv
module fureg_row
  import fureg_pkg::*;
#(
  parameter int NUM_REG = 8,
  parameter int REGW    = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load,
  input  logic                           clear,
  input  logic [NSLOT-1:0][REGW-1:0]     num,
  input  logic [NSLOT-1:0]               num_en,
  input  logic [NSLOT-1:0]               req,
  output logic                           busy,
  output logic [NSLOT-1:0][NUM_REG-1:0]  field,
  output logic [NSLOT-1:0][NUM_REG-1:0]  en
);
  logic [NSLOT-1:0][NUM_REG-1:0] decoded;

  always_ff @(posedge clk) begin
    if (!rst_n)     busy <= 1'b0;
    else if (clear) busy <= 1'b0;
    else if (load)  busy <= 1'b1;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    fureg_onehot #(.N(NUM_REG), .W(REGW)) u_dec (
      .idx (num[s]),
      .en  (num_en[s]),
      .vec (decoded[s])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)     field[s] <= '0;
      else if (clear) field[s] <= '0;
      else if (load)  field[s] <= decoded[s];
    end

    assign en[s] = req[s] ? field[s] : '0;
  end
endmodule

// File: rtl/fu_reg_matrix.sv
module fu_reg_matrix
  import fureg_pkg::*;
#(
  parameter int  NUM_FU  = 4,
  parameter int  NUM_REG = 8,
  localparam int FUW     = (NUM_FU  > 1) ? $clog2(NUM_FU)  : 1,
  localparam int REGW    = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issue_valid,
  output logic                  issue_ready,
  input  logic [FUW-1:0]        issue_fu,
  input  logic [REGW-1:0]       issue_dst,
  input  logic [REGW-1:0]       issue_src1,
  input  logic [REGW-1:0]       issue_src2,
  input  logic                  issue_dst_en,
  input  logic                  issue_src1_en,
  input  logic                  issue_src2_en,
  input  logic [2*NUM_FU-1:0]   rd_req,
  input  logic [NUM_FU-1:0]     wr_req,
  input  logic [NUM_FU-1:0]     done,
  output logic [NUM_REG-1:0]    rd_en_a,
  output logic [NUM_REG-1:0]    rd_en_b,
  output logic [NUM_REG-1:0]    wr_en,
  output logic [NUM_REG-1:0]    rd_pend,
  output logic [NUM_REG-1:0]    wr_pend,
  output logic [NUM_FU-1:0]     fu_busy
);
  logic                          fu_in_range;
  logic                          accept;
  logic [NSLOT-1:0][REGW-1:0]    slot_num;
  logic [NSLOT-1:0]              slot_en;

  logic [NUM_FU-1:0][NSLOT-1:0][NUM_REG-1:0] row_field;
  logic [NUM_FU-1:0][NSLOT-1:0][NUM_REG-1:0] row_en;

  logic [NUM_FU-1:0][NUM_REG-1:0] dst_cols;
  logic [NUM_FU-1:0][NUM_REG-1:0] src_cols;
  logic [NUM_FU-1:0][NUM_REG-1:0] wen_cols;
  logic [NUM_FU-1:0][NUM_REG-1:0] ren_a_cols;
  logic [NUM_FU-1:0][NUM_REG-1:0] ren_b_cols;

  assign fu_in_range = {1'b0, issue_fu} < (FUW+1)'(NUM_FU);
  assign issue_ready = fu_in_range && !fu_busy[issue_fu] && !done[issue_fu];
  assign accept      = issue_valid && issue_ready;

  assign slot_num[SLOT_DST]  = issue_dst;
  assign slot_num[SLOT_SRC1] = issue_src1;
  assign slot_num[SLOT_SRC2] = issue_src2;
  assign slot_en[SLOT_DST]   = issue_dst_en;
  assign slot_en[SLOT_SRC1]  = issue_src1_en;
  assign slot_en[SLOT_SRC2]  = issue_src2_en;

  for (genvar f = 0; f < NUM_FU; f++) begin : g_row
    logic [NSLOT-1:0] row_req;
    logic             row_load;

    assign row_load            = accept && (issue_fu == FUW'(f));
    assign row_req[SLOT_DST]   = wr_req[f];
    assign row_req[SLOT_SRC1]  = rd_req[2*f];
    assign row_req[SLOT_SRC2]  = rd_req[2*f+1];

    fureg_row #(.NUM_REG(NUM_REG), .REGW(REGW)) u_row (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (row_load),
      .clear  (done[f]),
      .num    (slot_num),
      .num_en (slot_en),
      .req    (row_req),
      .busy   (fu_busy[f]),
      .field  (row_field[f]),
      .en     (row_en[f])
    );

    assign dst_cols[f]   = row_field[f][SLOT_DST];
    assign src_cols[f]   = row_field[f][SLOT_SRC1] | row_field[f][SLOT_SRC2];
    assign wen_cols[f]   = row_en[f][SLOT_DST];
    assign ren_a_cols[f] = row_en[f][SLOT_SRC1];
    assign ren_b_cols[f] = row_en[f][SLOT_SRC2];
  end

  fureg_colreduce #(.ROWS(NUM_FU), .COLS(NUM_REG)) u_or_wen (
    .rows_in (wen_cols),   .col_or (wr_en));
  fureg_colreduce #(.ROWS(NUM_FU), .COLS(NUM_REG)) u_or_rena (
    .rows_in (ren_a_cols), .col_or (rd_en_a));
  fureg_colreduce #(.ROWS(NUM_FU), .COLS(NUM_REG)) u_or_renb (
    .rows_in (ren_b_cols), .col_or (rd_en_b));
  fureg_colreduce #(.ROWS(NUM_FU), .COLS(NUM_REG)) u_or_rpend (
    .rows_in (src_cols),   .col_or (rd_pend));
  fureg_colreduce #(.ROWS(NUM_FU), .COLS(NUM_REG)) u_or_wpend (
    .rows_in (dst_cols),   .col_or (wr_pend));
endmodule

// File: rtl/fureg_checker.sv
module fureg_checker #(
  parameter int  NUM_FU  = 4,
  parameter int  NUM_REG = 8,
  localparam int FUW     = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                issue_valid,
  input logic                issue_ready,
  input logic [FUW-1:0]      issue_fu,
  input logic [NUM_FU-1:0]   wr_req,
  input logic [NUM_FU-1:0]   done,
  input logic [NUM_REG-1:0]  wr_en,
  input logic [NUM_REG-1:0]  rd_pend,
  input logic [NUM_REG-1:0]  wr_pend,
  input logic [NUM_FU-1:0]   fu_busy
);
  AST_ISSUE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_ready |=> fu_busy[$past(issue_fu)]); // R2

  AST_BUSY_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    fu_busy[issue_fu] |-> !issue_ready); // R9

  AST_WEN_FROM_BUSY_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en != '0) |-> ((fu_busy & wr_req) != '0)); // R6

  AST_IDLE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (fu_busy == '0) |-> (rd_pend == '0 && wr_pend == '0)); // R7

  for (genvar f = 0; f < NUM_FU; f++) begin : g_row_chk
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      done[f] |=> !fu_busy[f]); // R8
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      fu_busy[f] && !done[f] |=> fu_busy[f]); // R8
  end
endmodule

bind fu_reg_matrix fureg_checker #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_chk (.*);

// File: tb/sim_fu_reg_matrix.sv
`timescale 1ns/1ps
module sim_fu_reg_matrix;
  localparam int NUM_FU  = 4;
  localparam int NUM_REG = 8;
  localparam int FUW     = 2;
  localparam int REGW    = 3;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 issue_valid;
  logic                 issue_ready;
  logic [FUW-1:0]       issue_fu;
  logic [REGW-1:0]      issue_dst, issue_src1, issue_src2;
  logic                 issue_dst_en, issue_src1_en, issue_src2_en;
  logic [2*NUM_FU-1:0]  rd_req;
  logic [NUM_FU-1:0]    wr_req;
  logic [NUM_FU-1:0]    done;
  logic [NUM_REG-1:0]   rd_en_a, rd_en_b, wr_en, rd_pend, wr_pend;
  logic [NUM_FU-1:0]    fu_busy;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fu_reg_matrix #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    issue_valid = 0; issue_fu = '0;
    issue_dst = '0; issue_src1 = '0; issue_src2 = '0;
    issue_dst_en = 0; issue_src1_en = 0; issue_src2_en = 0;
    rd_req = '0; wr_req = '0; done = '0;
  endtask

  // Drives one issue for a full cycle; leaves state updated after the negedge.
  task automatic do_issue(input int fu, input int d, input int s1, input int s2,
                          input bit de, input bit s1e, input bit s2e);
    @(negedge clk);
    issue_valid = 1; issue_fu = FUW'(fu);
    issue_dst = REGW'(d); issue_src1 = REGW'(s1); issue_src2 = REGW'(s2);
    issue_dst_en = de; issue_src1_en = s1e; issue_src2_en = s2e;
    @(negedge clk);
    issue_valid = 0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 busy", 32'(fu_busy), 0);
    chk("R1 pend", {rd_pend, wr_pend}, 0);
    chk("R1 enables", {rd_en_a, rd_en_b, wr_en}, 0);
    chk("R1 ready", 32'(issue_ready), 1);
  endtask

  task automatic t_issue_basic();
    do_issue(1, 3, 5, 0, 1, 1, 1);
    #1;
    chk("R2 busy", 32'(fu_busy), 32'h2);
    chk("R7 rd_pend", 32'(rd_pend), 32'h21);
    chk("R7 wr_pend", 32'(wr_pend), 32'h08);
    rd_req = 8'b0000_0100; #1;
    chk("R4 port a", 32'(rd_en_a), 32'h20);
    chk("R4 port b idle", 32'(rd_en_b), 0);
    rd_req = 8'b0000_1000; #1;
    chk("R4 port b", 32'(rd_en_b), 32'h01);
    rd_req = '0; wr_req = 4'b0010; #1;
    chk("R5 write", 32'(wr_en), 32'h08);
    wr_req = '0;
  endtask

  task automatic t_disabled_and_idle();
    do_issue(2, 7, 2, 6, 1, 1, 0);
    #1;
    chk("R3 pend excludes disabled", 32'(rd_pend), 32'h25);
    rd_req = 8'b0010_0000; #1;
    chk("R3 disabled slot", 32'(rd_en_b), 0);
    rd_req = 8'b0000_0011; wr_req = 4'b0001; #1;
    chk("R6 idle row", {rd_en_a, rd_en_b, wr_en}, 0);
    rd_req = '0; wr_req = '0;
  endtask

  task automatic t_multi_row();
    rd_req = 8'b0001_0100; #1;
    chk("R10 or of rows", 32'(rd_en_a), 32'h24);
    rd_req = '0; wr_req = 4'b0110; #1;
    chk("R10 write or", 32'(wr_en), 32'h88);
    wr_req = '0;
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    issue_valid = 1; issue_fu = 2'd1;
    issue_dst = 3'd6; issue_src1 = 3'd6; issue_src2 = 3'd6;
    issue_dst_en = 1; issue_src1_en = 1; issue_src2_en = 1;
    #1;
    chk("R9 ready low", 32'(issue_ready), 0);
    @(negedge clk);
    issue_valid = 0;
    #1;
    chk("R9 rd_pend kept", 32'(rd_pend), 32'h25);
    chk("R9 wr_pend kept", 32'(wr_pend), 32'h88);
    wr_req = 4'b0010; #1;
    chk("R9 row1 dst kept", 32'(wr_en), 32'h08);
    wr_req = '0;
  endtask

  task automatic t_done();
    @(negedge clk);
    done = 4'b0010;
    @(negedge clk);
    done = '0;
    #1;
    chk("R8 busy", 32'(fu_busy), 32'h4);
    chk("R8 rd_pend", 32'(rd_pend), 32'h04);
    chk("R8 wr_pend", 32'(wr_pend), 32'h80);
    rd_req = 8'b0000_0100; #1;
    chk("R6 cleared row", 32'(rd_en_a), 0);
    rd_req = '0;
  endtask

  task automatic t_done_with_issue();
    @(negedge clk);
    done = 4'b0100;
    issue_valid = 1; issue_fu = 2'd2;
    issue_dst = 3'd0; issue_src1 = 3'd1; issue_src2 = 3'd1;
    issue_dst_en = 1; issue_src1_en = 1; issue_src2_en = 1;
    #1;
    chk("R9 ready low on done", 32'(issue_ready), 0);
    @(negedge clk);
    done = '0; issue_valid = 0;
    #1;
    chk("R8 cleared despite issue", 32'(fu_busy), 0);
    chk("R8 pend clear", {rd_pend, wr_pend}, 0);
  endtask

  task automatic t_same_cycle_req();
    @(negedge clk);
    issue_valid = 1; issue_fu = 2'd3;
    issue_dst = 3'd1; issue_src1 = 3'd4; issue_src2 = 3'd4;
    issue_dst_en = 1; issue_src1_en = 1; issue_src2_en = 1;
    rd_req = 8'b1100_0000;
    #1;
    chk("R11 no enable in issue cycle", {rd_en_a, rd_en_b}, 0);
    @(negedge clk);
    issue_valid = 0;
    #1;
    chk("R11 enable next cycle", 32'(rd_en_a), 32'h10);
    chk("R3 same reg both slots", 32'(rd_en_b), 32'h10);
    chk("R7 shared reg pend", 32'(rd_pend), 32'h10);
    rd_req = '0;
  endtask

  initial begin
    t_reset();
    t_issue_basic();
    t_disabled_and_idle();
    t_multi_row();
    t_busy_ignore();
    t_done();
    t_done_with_issue();
    t_same_cycle_req();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule